// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block performs interrupt entry for a small 8-bit microcontroller core. It holds a register of pending hardware sources and a latched reset request. When the core's global interrupt enable is set and no instruction skip is outstanding, it accepts one request. A reset request always takes precedence; otherwise the lowest-numbered pending source is taken. The block then saves the current word program counter on a byte-wide stack in data memory, one byte per clock, through a simple write port. Finally it hands the core a vector address and a new stack pointer, and pulses a request to clear the global enable.

The core supplies the enable, the skip flag, the program counter and the stack pointer. It applies the `pc_new_o`, `sp_new_o` and `gie_clr_o` values in the cycle marked by `pc_load_o`, and does not fetch while `busy_o` is high. Two configuration inputs set how many program counter bytes are saved and whether each vector slot is one word or two words wide.

Top module: `irq_entry_seq`

## Requirements
- R1: While `skip_i` is high, no request is accepted, neither reset nor hardware, and `busy_o` stays low; the request is taken once `skip_i` falls.
- R2: A latched reset request is served before any pending hardware bit. It uses vector number 0 and leaves every pending bit untouched.
- R3: Acceptance needs `gie_i` high and either a latched reset request or at least one pending bit. With `gie_i` low, or with nothing pending, `busy_o` stays low.
- R4: Among the pending bits, the lowest set index is served. Its vector number is that index plus one.
- R5: `pc_new_o` equals the vector number times the slot size. The slot size is 2 words when `long_slot_i` is 1 and 1 word when it is 0, starting from address 0.
- R6: The return address is written one byte per cycle to the current stack pointer, which then decrements. Bits 7:0 go first, then bits 15:8, then bits 23:16. `pc_bytes_i` gives the count: 1, 2 or 3, with the code 0 acting as 1.
- R7: In the single cycle after the last stack write, `pc_load_o` and `gie_clr_o` are both high.
- R8: Acceptance of a hardware source clears only that source's pending bit. `irq_line_o` stays high while any pending bit or the reset request remains.
- R9: `busy_o` is high from the cycle after acceptance through the `pc_load_o` cycle, and low in the cycle after that. Stack writes occur only while busy.
- R10: The stack pointer wraps modulo 2^SP_W on decrement. `sp_new_o` equals the starting stack pointer minus the number of bytes written.
- R11: A reset request stays latched, and keeps `irq_line_o` high, until its own entry reaches the `pc_load_o` cycle. It is then cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_set_i | input | NUM_SRC | One-cycle pulses that set pending source bits |
| rst_req_i | input | 1 | Pulse that latches a reset request |
| gie_i | input | 1 | Global interrupt enable from the core |
| skip_i | input | 1 | Skip of the next instruction is outstanding |
| pc_i | input | PC_W | Current word program counter (return address) |
| sp_i | input | SP_W | Current stack pointer |
| pc_bytes_i | input | 2 | Return address bytes to save (0 or 1 gives 1, 2, 3) |
| long_slot_i | input | 1 | 1 gives 2-word vector slots, 0 gives 1-word slots |
| busy_o | output | 1 | Entry sequence running; the core must not fetch |
| mem_we_o | output | 1 | Stack byte write strobe |
| mem_addr_o | output | SP_W | Stack write address |
| mem_wdata_o | output | 8 | Stack write data |
| pc_load_o | output | 1 | Core loads `pc_new_o` and `sp_new_o` this cycle |
| pc_new_o | output | PC_W | Vector address |
| sp_new_o | output | SP_W | Stack pointer after the pushes |
| gie_clr_o | output | 1 | Request to clear the global enable |
| pend_o | output | NUM_SRC | Pending source bits |
| irq_line_o | output | 1 | Any pending bit or reset request outstanding |

## Verification
The bench sets two pending bits together and checks that the lower one is served first while the other stays pending. A design that searched from the top, or cleared the whole register, would give the wrong vector or drop the line. It raises a reset request alongside a pending bit and then releases it. A design that let hardware win, or cleared the reset request at acceptance rather than at completion, would enter the wrong vector or enter reset twice. Skip and a low enable are held for several cycles to catch early acceptance. Three-byte pushes near address 0 show whether the byte order is correct and whether the stack pointer wraps.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_LOAD = 2'd2
  } seq_state_e;

  // Lowest set bit of a vector of up to 32 sources; 0 when empty.
  function automatic logic [4:0] lowest_set(input logic [31:0] v);
    logic [4:0] r;
    r = 5'd0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

  // Word address of a vector slot.
  function automatic logic [31:0] slot_addr(input logic [5:0] vnum, input logic long_slot);
    return long_slot ? {25'd0, vnum, 1'b0} : {26'd0, vnum};
  endfunction

  // Configured number of saved program counter bytes, 0 treated as 1.
  function automatic logic [1:0] push_count(input logic [1:0] cfg);
    return (cfg == 2'd0) ? 2'd1 : cfg;
  endfunction

endpackage

// File: rtl/irq_src_pick.sv
module irq_src_pick #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_SRC-1:0] onehot_o
);
  import irq_entry_pkg::*;

  logic [NUM_SRC:0] below_any;
  assign below_any[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign onehot_o[g]    = pend_i[g] & ~below_any[g];
    assign below_any[g+1] = below_any[g] | pend_i[g];
  end

  assign any_o = below_any[NUM_SRC];
  assign idx_o = IDX_W'(lowest_set(32'(pend_i)));

endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
  parameter int NUM_SRC = 8,
  parameter int PC_W    = 22,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             is_rst_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             long_slot_i,
  output logic [PC_W-1:0]  vec_pc_o
);
  import irq_entry_pkg::*;

  logic [5:0] vnum;
  assign vnum     = is_rst_i ? 6'd0 : (6'(idx_i) + 6'd1);
  assign vec_pc_o = PC_W'(slot_addr(vnum, long_slot_i));

endmodule

// File: rtl/irq_stack_push.sv
module irq_stack_push #(
  parameter int PC_W = 22,
  parameter int SP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [PC_W-1:0] ret_pc_i,
  input  logic [SP_W-1:0] sp_i,
  input  logic [1:0]      nbytes_i,
  input  logic [PC_W-1:0] vec_pc_i,
  output logic            busy_o,
  output logic            we_o,
  output logic [SP_W-1:0] addr_o,
  output logic [7:0]      wdata_o,
  output logic            load_o,
  output logic [PC_W-1:0] pc_new_o,
  output logic [SP_W-1:0] sp_new_o
);
  import irq_entry_pkg::*;

  seq_state_e      st_q;
  logic [23:0]     ret_q;
  logic [SP_W-1:0] sp_q;
  logic [1:0]      cnt_q, nb_q;
  logic [PC_W-1:0] vec_q;
  logic            last_w;

  assign last_w = (cnt_q == (nb_q - 2'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ret_q <= '0;
      sp_q  <= '0;
      cnt_q <= '0;
      nb_q  <= 2'd1;
      vec_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          ret_q <= 24'(ret_pc_i);
          sp_q  <= sp_i;
          cnt_q <= 2'd0;
          nb_q  <= nbytes_i;
          vec_q <= vec_pc_i;
          st_q  <= ST_PUSH;
        end
        ST_PUSH: begin
          sp_q  <= sp_q - SP_W'(1);
          cnt_q <= cnt_q + 2'd1;
          if (last_w) st_q <= ST_LOAD;
        end
        ST_LOAD: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (cnt_q)
      2'd0:    wdata_o = ret_q[7:0];
      2'd1:    wdata_o = ret_q[15:8];
      default: wdata_o = ret_q[23:16];
    endcase
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign we_o     = (st_q == ST_PUSH);
  assign addr_o   = sp_q;
  assign load_o   = (st_q == ST_LOAD);
  assign pc_new_o = vec_q;
  assign sp_new_o = sp_q;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int NUM_SRC = 8,
  parameter int PC_W    = 22,
  parameter int SP_W    = 16,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_set_i,
  input  logic               rst_req_i,
  input  logic               gie_i,
  input  logic               skip_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [SP_W-1:0]    sp_i,
  input  logic [1:0]         pc_bytes_i,
  input  logic               long_slot_i,
  output logic               busy_o,
  output logic               mem_we_o,
  output logic [SP_W-1:0]    mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  output logic               pc_load_o,
  output logic [PC_W-1:0]    pc_new_o,
  output logic [SP_W-1:0]    sp_new_o,
  output logic               gie_clr_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_line_o
);
  import irq_entry_pkg::*;

  logic [NUM_SRC-1:0] pend_q;
  logic               rst_pend_q;
  logic               rst_entry_q;

  // Named internal events, observed by the bound checker.
  logic               accept_w;
  logic               rst_sel_w;
  logic               rst_done_w;
  logic [NUM_SRC-1:0] clr_mask_w;

  logic               src_any;
  logic [IDX_W-1:0]   src_idx;
  logic [NUM_SRC-1:0] src_onehot;
  logic [PC_W-1:0]    vec_pc;

  irq_src_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend_i   (pend_q),
    .any_o    (src_any),
    .idx_o    (src_idx),
    .onehot_o (src_onehot)
  );

  irq_vec_gen #(.NUM_SRC(NUM_SRC), .PC_W(PC_W)) u_vec (
    .is_rst_i    (rst_sel_w),
    .idx_i       (src_idx),
    .long_slot_i (long_slot_i),
    .vec_pc_o    (vec_pc)
  );

  irq_stack_push #(.PC_W(PC_W), .SP_W(SP_W)) u_push (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (accept_w),
    .ret_pc_i (pc_i),
    .sp_i     (sp_i),
    .nbytes_i (push_count(pc_bytes_i)),
    .vec_pc_i (vec_pc),
    .busy_o   (busy_o),
    .we_o     (mem_we_o),
    .addr_o   (mem_addr_o),
    .wdata_o  (mem_wdata_o),
    .load_o   (pc_load_o),
    .pc_new_o (pc_new_o),
    .sp_new_o (sp_new_o)
  );

  assign rst_sel_w  = rst_pend_q;
  assign accept_w   = !busy_o && !skip_i && gie_i && (rst_pend_q || src_any);
  assign clr_mask_w = (accept_w && !rst_sel_w) ? src_onehot : '0;
  assign rst_done_w = pc_load_o && rst_entry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      rst_pend_q  <= 1'b0;
      rst_entry_q <= 1'b0;
    end else begin
      pend_q     <= (pend_q & ~clr_mask_w) | pend_set_i;
      rst_pend_q <= rst_req_i | (rst_pend_q & ~rst_done_w);
      if (accept_w) rst_entry_q <= rst_sel_w;
    end
  end

  assign gie_clr_o  = pc_load_o;
  assign pend_o     = pend_q;
  assign irq_line_o = rst_pend_q | (|pend_q);

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int NUM_SRC = 8,
  parameter int SP_W    = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               skip_i,
  input logic               gie_i,
  input logic               busy_o,
  input logic               mem_we_o,
  input logic [SP_W-1:0]    mem_addr_o,
  input logic               pc_load_o,
  input logic               gie_clr_o,
  input logic               accept_w,
  input logic               rst_sel_w,
  input logic               rst_pend_w,
  input logic [NUM_SRC-1:0] clr_mask_w,
  input logic               irq_line_o
);

  assert_skip_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_i && !busy_o) |=> !busy_o);

  assert_rst_keeps_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && rst_sel_w) |-> (clr_mask_w == '0));

  assert_gie_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_i && !busy_o) |=> !busy_o);

  assert_push_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == SP_W'($past(mem_addr_o) - SP_W'(1))));

  assert_load_clears_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> (gie_clr_o && !mem_we_o && busy_o));

  assert_single_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_mask_w));

  assert_line_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && rst_sel_w) |=> irq_line_o);

  assert_write_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  assert_load_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |=> !busy_o);

  assert_rst_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pend_w && !pc_load_o) |=> rst_pend_w);

endmodule

bind irq_entry_seq irq_entry_chk #(.NUM_SRC(NUM_SRC), .SP_W(SP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .skip_i     (skip_i),
  .gie_i      (gie_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .pc_load_o  (pc_load_o),
  .gie_clr_o  (gie_clr_o),
  .accept_w   (accept_w),
  .rst_sel_w  (rst_sel_w),
  .rst_pend_w (rst_pend_q),
  .clr_mask_w (clr_mask_w),
  .irq_line_o (irq_line_o)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam int NS = 8;
  localparam int PW = 22;
  localparam int SW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [NS-1:0] pend_set_i = '0;
  logic          rst_req_i = 1'b0;
  logic          gie_i = 1'b0;
  logic          skip_i = 1'b0;
  logic [PW-1:0] pc_i = '0;
  logic [SW-1:0] sp_i = '0;
  logic [1:0]    pc_bytes_i = 2'd2;
  logic          long_slot_i = 1'b0;
  logic          busy_o, mem_we_o, pc_load_o, gie_clr_o, irq_line_o;
  logic [SW-1:0] mem_addr_o, sp_new_o;
  logic [7:0]    mem_wdata_o;
  logic [PW-1:0] pc_new_o;
  logic [NS-1:0] pend_o;

  irq_entry_seq #(.NUM_SRC(NS), .PC_W(PW), .SP_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pend_set_i(pend_set_i), .rst_req_i(rst_req_i),
    .gie_i(gie_i), .skip_i(skip_i), .pc_i(pc_i), .sp_i(sp_i),
    .pc_bytes_i(pc_bytes_i), .long_slot_i(long_slot_i), .busy_o(busy_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .pc_load_o(pc_load_o), .pc_new_o(pc_new_o), .sp_new_o(sp_new_o),
    .gie_clr_o(gie_clr_o), .pend_o(pend_o), .irq_line_o(irq_line_o)
  );

  // Core model: the enable is cleared on the requested edge.
  always @(posedge clk) if (gie_clr_o) gie_i <= 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int          n_wr;
  logic [15:0] wa [3];
  logic [7:0]  wd [3];
  logic [31:0] got_pc, got_sp;
  logic        got_clr, got_line, seen_load, busy_bad;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_vec(input int idx, input bit lng);
    return 32'((idx + 1) * (lng ? 2 : 1));
  endfunction

  task automatic pulse_pend(input logic [NS-1:0] m);
    @(negedge clk); pend_set_i = m;
    @(negedge clk); pend_set_i = '0;
  endtask

  // Collect one entry sequence: stack writes and the load cycle.
  task automatic capture();
    n_wr = 0; seen_load = 0; busy_bad = 0;
    for (int c = 0; c < 30 && !seen_load; c++) begin
      @(negedge clk);
      if (mem_we_o) begin
        if (!busy_o) busy_bad = 1;
        if (n_wr < 3) begin wa[n_wr] = mem_addr_o; wd[n_wr] = mem_wdata_o; end
        n_wr++;
      end
      if (pc_load_o) begin
        seen_load = 1; got_pc = 32'(pc_new_o); got_sp = 32'(sp_new_o);
        got_clr = gie_clr_o; got_line = irq_line_o;
        if (!busy_o) busy_bad = 1;
      end
    end
    chk("R9 load seen", 32'(seen_load), 1);
    chk("R9 busy during entry", 32'(busy_bad), 0);
    chk("R7 gie_clr with load", 32'(got_clr), 1);
    @(negedge clk);
    chk("R9 idle after load", 32'(busy_o), 0);
    chk("R7 enable cleared", 32'(gie_i), 0);
  endtask

  task automatic hold_idle(input int n, input string req);
    logic bad = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (busy_o || mem_we_o) bad = 1;
    end
    chk(req, 32'(bad), 0);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R9 reset busy", 32'(busy_o), 0);
    chk("R6 reset we", 32'(mem_we_o), 0);
    chk("R8 reset line", 32'(irq_line_o), 0);
    chk("R8 reset pend", 32'(pend_o), 0);
  endtask

  task automatic t_two_bytes();
    pc_i = 22'h123456; sp_i = 16'h08FF; pc_bytes_i = 2'd2; long_slot_i = 1; gie_i = 1;
    pulse_pend(8'h08);
    capture();
    chk("R6 write count", 32'(n_wr), 2);
    chk("R6 addr0", 32'(wa[0]), 32'h08FF); chk("R6 data0", 32'(wd[0]), 32'h56);
    chk("R6 addr1", 32'(wa[1]), 32'h08FE); chk("R6 data1", 32'(wd[1]), 32'h34);
    chk("R5 long vector", got_pc, exp_vec(3, 1));
    chk("R10 sp_new", got_sp, 32'h08FD);
    chk("R8 line clear", 32'(irq_line_o), 0);
  endtask

  task automatic t_priority();
    pc_i = 22'h0000AB; sp_i = 16'h0400; pc_bytes_i = 2'd1; long_slot_i = 0; gie_i = 1;
    pulse_pend(8'h24);
    capture();
    chk("R6 one byte", 32'(n_wr), 1);
    chk("R6 byte", 32'(wd[0]), 32'hAB);
    chk("R4 lowest first", got_pc, exp_vec(2, 0));
    chk("R8 other bit kept", 32'(pend_o), 32'h20);
    chk("R8 line stays", 32'(irq_line_o), 1);
    hold_idle(4, "R3 enable now low");
    @(negedge clk); gie_i = 1;
    capture();
    chk("R4 second source", got_pc, exp_vec(5, 0));
    chk("R8 line drops", 32'(irq_line_o), 0);
  endtask

  task automatic t_wrap();
    pc_i = 22'h21B2C3; sp_i = 16'h0001; pc_bytes_i = 2'd3; long_slot_i = 1; gie_i = 1;
    pulse_pend(8'h80);
    capture();
    chk("R6 three bytes", 32'(n_wr), 3);
    chk("R6 low byte", 32'(wd[0]), 32'hC3);
    chk("R6 mid byte", 32'(wd[1]), 32'hB2);
    chk("R6 high byte", 32'(wd[2]), 32'h21);
    chk("R10 wrap addr", 32'(wa[2]), 32'hFFFF);
    chk("R10 wrap sp_new", got_sp, 32'hFFFE);
    chk("R5 top source", got_pc, exp_vec(7, 1));
  endtask

  task automatic t_gie_low();
    pc_bytes_i = 2'd0; long_slot_i = 0; sp_i = 16'h0200; gie_i = 0;
    pulse_pend(8'h02);
    hold_idle(8, "R3 gie low blocks");
    chk("R3 still pending", 32'(irq_line_o), 1);
    @(negedge clk); gie_i = 1;
    capture();
    chk("R6 code 0 acts as 1", 32'(n_wr), 1);
    chk("R5 short vector", got_pc, exp_vec(1, 0));
  endtask

  task automatic t_skip();
    skip_i = 1; gie_i = 1; long_slot_i = 1; pc_bytes_i = 2'd2;
    @(negedge clk); rst_req_i = 1;
    @(negedge clk); rst_req_i = 0;
    hold_idle(8, "R1 skip blocks reset");
    @(negedge clk); skip_i = 0;
    capture();
    chk("R2 reset vector", got_pc, 0);
    chk("R11 line held to load", 32'(got_line), 1);
    chk("R11 cleared after", 32'(irq_line_o), 0);
  endtask

  task automatic t_reset_first();
    gie_i = 1; long_slot_i = 1; pc_bytes_i = 2'd1;
    @(negedge clk); rst_req_i = 1; pend_set_i = 8'h01;
    @(negedge clk); rst_req_i = 0; pend_set_i = '0;
    capture();
    chk("R2 reset wins", got_pc, 0);
    chk("R2 pending untouched", 32'(pend_o), 1);
    @(negedge clk); gie_i = 1;
    capture();
    chk("R11 reset not retaken", got_pc, exp_vec(0, 1));
    chk("R8 all served", 32'(irq_line_o), 0);
  endtask

  task automatic t_nothing_pending();
    gie_i = 1;
    hold_idle(6, "R3 no pending no entry");
    gie_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_state();
    t_two_bytes();
    t_priority();
    t_wrap();
    t_gie_low();
    t_skip();
    t_reset_first();
    t_nothing_pending();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule